// File: doc/BRIEF.md
# BCD Time-of-Day Nibble Port

This block keeps the time of day and the calendar date as packed BCD bytes and lets a host read them one 4-bit digit at a time. It has two byte-wide registers, chosen by a one-bit register select. Writing the command register loads a 4-bit digit pointer and a 4-bit flag nibble. Reading the data register returns the digit that the pointer selects, with the digit in the low four bits.

A one-second tick input drives the timekeeping chain. It counts seconds, minutes and hours, and each day carry also advances a weekday and a day-of-month counter. Day carries feed month, and month carries feed year. The hold flag freezes the chain, so software can read several digits and get a consistent picture. The hour-tens digit also reports that the clock runs in 24-hour format.

Top module: `rtc_nibble_port`

## Requirements
- R1: After a synchronous reset, the digit pointer is 0 and the flag nibble is 0. The time fields take their parameter reset values, which default to 00:00:00, weekday 0, day 1, month 1 and year 0.
- R2: A write with `reg_sel`=0 loads `wr_data[3:0]` into the digit pointer and `wr_data[7:4]` into the flag nibble. Flag bit 2 is hold, bit 1 is write and bit 0 is read. Both fields are visible from the cycle after the write edge.
- R3: While `reg_sel`=0, `rd_data` is 0xFF.
- R4: While `reg_sel`=1, `rd_data[7:4]` is 0 and `rd_data[3:0]` is the selected digit. Pointer 0/1 gives seconds units/tens, 2/3 minutes units/tens, 4 hour units, 6 weekday, 7/8 day units/tens, 9/10 month units/tens, and 11/12 year units/tens.
- R5: Pointer 5 returns the hour tens in bits 1:0 with bit 3 set to 1, which marks 24-hour format. Bit 2 is 0.
- R6: Pointer values 13, 14 and 15 read as 0x00.
- R7: A write with `reg_sel`=1 changes neither the pointer, the flags nor the time.
- R8: A `tick_1s` pulse sampled at a clock edge while hold is clear advances the seconds by one in BCD, visible from the next cycle.
- R9: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries one step into the next field.
- R10: While the hold flag is set, `tick_1s` leaves every time field unchanged.
- R11: An hour wrap advances the weekday (6 wraps to 0) and the day (31 wraps to 1). A day wrap advances the month (12 wraps to 1), and a month wrap advances the year (99 wraps to 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| tick_1s | input | 1 | One-second advance pulse, one clock wide |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| flags | output | 4 | Flag nibble: bit 2 hold, bit 1 write, bit 0 read |

## Verification
The bench builds the block with reset values of 23:59:50 on day 31, month 12, year 99, weekday 6. The first ten ticks therefore carry through every wrap at once: seconds, minutes, hours, weekday, day, month and year. All sixteen pointer values are swept against an arithmetic model after each tick. A further run of 86,400 ticks covers one full day, which brings in the non-wrapping day and weekday increments and the 24-hour indicator at each hour-tens value. The hold and data-write checks then repeat the full sweep, so that any disturbance of any field shows up.

// File: rtl/rtc_nib_pkg.sv
package rtc_nib_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int BUS_W      = 8;
    localparam int NIB_W      = 4;
    localparam int PTR_W      = 4;
    localparam int FLAG_W     = BUS_W - PTR_W;

    localparam int IX_SEC  = 0;
    localparam int IX_MIN  = 1;
    localparam int IX_HOUR = 2;
    localparam int IX_WDAY = 3;
    localparam int IX_DAY  = 4;
    localparam int IX_MON  = 5;
    localparam int IX_YEAR = 6;

    typedef logic [7:0] bcd2_t;

    typedef enum logic {
        PORT_CMD  = 1'b0,
        PORT_DATA = 1'b1
    } port_e;

    typedef struct packed {
        logic spare;
        logic hold;
        logic wr;
        logic rd;
    } flag_t;

    typedef struct packed {
        bcd2_t year;
        bcd2_t mon;
        bcd2_t day;
        bcd2_t wday;
        bcd2_t hour;
        bcd2_t min;
        bcd2_t sec;
    } rtc_time_t;

    function automatic bcd2_t to_bcd(input int v);
        bcd2_t r;
        r[7:4] = 4'((v / 10) % 10);
        r[3:0] = 4'(v % 10);
        return r;
    endfunction

    function automatic bcd2_t bcd_inc(input bcd2_t v);
        bcd2_t r;
        if (v[3:0] >= 4'd9) begin
            r[7:4] = v[7:4] + 4'd1;
            r[3:0] = 4'd0;
        end else begin
            r[7:4] = v[7:4];
            r[3:0] = v[3:0] + 4'd1;
        end
        return r;
    endfunction

    function automatic int field_min(input int ix);
        return (ix == IX_DAY || ix == IX_MON) ? 1 : 0;
    endfunction

    function automatic int field_max(input int ix);
        case (ix)
            IX_SEC, IX_MIN: return 59;
            IX_HOUR:        return 23;
            IX_WDAY:        return 6;
            IX_DAY:         return 31;
            IX_MON:         return 12;
            default:        return 99;
        endcase
    endfunction

    // Which field's carry steps field ix; -1 means the gated tick.
    function automatic int carry_src(input int ix);
        case (ix)
            IX_SEC:          return -1;
            IX_MIN:          return IX_SEC;
            IX_HOUR:         return IX_MIN;
            IX_WDAY, IX_DAY: return IX_HOUR;
            IX_MON:          return IX_DAY;
            default:         return IX_MON;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_nib_pkg::*;
#(
    parameter int MIN_V = 0,
    parameter int MAX_V = 59,
    parameter int RST_V = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output bcd2_t q,
    output logic  carry
);
    localparam bcd2_t MIN_B = to_bcd(MIN_V);
    localparam bcd2_t MAX_B = to_bcd(MAX_V);
    localparam bcd2_t RST_B = to_bcd(RST_V);

    logic at_max;
    assign at_max = (q == MAX_B);
    assign carry  = step && at_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_B;
        end else if (step) begin
            q <= at_max ? MIN_B : bcd_inc(q);
        end
    end

    // R9
    wrap_to_min_chk: assert property (@(posedge clk) disable iff (rst)
        (step && q == MAX_B) |=> (q == MIN_B));

    // R8
    step_bcd_chk: assert property (@(posedge clk) disable iff (rst)
        (step && q != MAX_B) |=> (q[3:0] == (($past(q[3:0]) == 4'd9) ? 4'd0 : $past(q[3:0]) + 4'd1)));

    // R11
    q_range_chk: assert property (@(posedge clk) disable iff (rst)
        (q[3:0] <= 4'd9) && (q >= MIN_B) && (q <= MAX_B));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_nib_pkg::*;
#(
    parameter int RST_SEC  = 0,
    parameter int RST_MIN  = 0,
    parameter int RST_HOUR = 0,
    parameter int RST_WDAY = 0,
    parameter int RST_DAY  = 1,
    parameter int RST_MON  = 1,
    parameter int RST_YEAR = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      hold,
    output rtc_time_t time_o
);
    localparam int RST_TAB [NUM_FIELDS] =
        '{RST_SEC, RST_MIN, RST_HOUR, RST_WDAY, RST_DAY, RST_MON, RST_YEAR};

    logic [NUM_FIELDS-1:0] step;
    logic [NUM_FIELDS-1:0] carry;
    bcd2_t                 val [NUM_FIELDS];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int SRC = carry_src(i);
        if (SRC < 0) begin : g_head
            assign step[i] = tick && !hold;
        end else begin : g_link
            assign step[i] = carry[SRC];
        end
        rtc_bcd_field #(
            .MIN_V(field_min(i)),
            .MAX_V(field_max(i)),
            .RST_V(RST_TAB[i])
        ) u_field (
            .clk  (clk),
            .rst  (rst),
            .step (step[i]),
            .q    (val[i]),
            .carry(carry[i])
        );
    end

    assign time_o = {val[IX_YEAR], val[IX_MON], val[IX_DAY], val[IX_WDAY],
                     val[IX_HOUR], val[IX_MIN], val[IX_SEC]};

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(time_o));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(time_o));

    // R11
    wday_follows_day_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(val[IX_DAY]) |-> $changed(val[IX_WDAY]));

endmodule

// File: rtl/rtc_digit_mux.sv
module rtc_digit_mux
    import rtc_nib_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    input  rtc_time_t        time_i,
    output logic [NIB_W-1:0] nib
);
    always_comb begin
        case (ptr)
            4'd0:    nib = time_i.sec[3:0];
            4'd1:    nib = time_i.sec[7:4];
            4'd2:    nib = time_i.min[3:0];
            4'd3:    nib = time_i.min[7:4];
            4'd4:    nib = time_i.hour[3:0];
            4'd5:    nib = {1'b1, 1'b0, time_i.hour[5:4]};
            4'd6:    nib = time_i.wday[3:0];
            4'd7:    nib = time_i.day[3:0];
            4'd8:    nib = time_i.day[7:4];
            4'd9:    nib = time_i.mon[3:0];
            4'd10:   nib = time_i.mon[7:4];
            4'd11:   nib = time_i.year[3:0];
            4'd12:   nib = time_i.year[7:4];
            default: nib = '0;
        endcase
    end

    // R5
    always_comb begin
        if (ptr == 4'd5) begin
            hour_flag_chk: assert (nib[3] && !nib[2]);
        end
    end

    // R6
    always_comb begin
        if (ptr > 4'd12) begin
            high_ptr_zero_chk: assert (nib == '0);
        end
    end

endmodule

// File: rtl/rtc_nibble_port.sv
module rtc_nibble_port
    import rtc_nib_pkg::*;
#(
    parameter int RST_SEC  = 0,
    parameter int RST_MIN  = 0,
    parameter int RST_HOUR = 0,
    parameter int RST_WDAY = 0,
    parameter int RST_DAY  = 1,
    parameter int RST_MON  = 1,
    parameter int RST_YEAR = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tick_1s,
    output logic [7:0] rd_data,
    output logic [3:0] flags
);
    logic [PTR_W-1:0] ptr_q;
    flag_t            flag_q;
    rtc_time_t        now;
    logic [NIB_W-1:0] nib;
    logic             cmd_wr;

    assign cmd_wr = wr_en && (port_e'(reg_sel) == PORT_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            flag_q <= '0;
        end else if (cmd_wr) begin
            ptr_q  <= wr_data[PTR_W-1:0];
            flag_q <= flag_t'(wr_data[BUS_W-1:PTR_W]);
        end
    end

    rtc_time_chain #(
        .RST_SEC (RST_SEC),
        .RST_MIN (RST_MIN),
        .RST_HOUR(RST_HOUR),
        .RST_WDAY(RST_WDAY),
        .RST_DAY (RST_DAY),
        .RST_MON (RST_MON),
        .RST_YEAR(RST_YEAR)
    ) u_chain (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_1s),
        .hold  (flag_q.hold),
        .time_o(now)
    );

    rtc_digit_mux u_mux (
        .ptr   (ptr_q),
        .time_i(now),
        .nib   (nib)
    );

    assign rd_data = (port_e'(reg_sel) == PORT_CMD) ? {BUS_W{1'b1}}
                                                    : {{(BUS_W-NIB_W){1'b0}}, nib};
    assign flags   = flag_q;

    // R2
    cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !reg_sel) |=> (flags == $past(wr_data[7:4])));

    // R7
    data_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel) |=> $stable(flags) && $stable(ptr_q));

    // R3
    cmd_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (rd_data == 8'hFF));

endmodule

// File: tb/rtc_nibble_port_bench.sv
module rtc_nibble_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick_1s = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] flags;

    int n_cmp = 0;
    int n_bad = 0;

    int m_sec = 50, m_min = 59, m_hour = 23, m_wday = 6, m_day = 31, m_mon = 12, m_year = 99;

    always #5 clk = ~clk;

    rtc_nibble_port #(
        .RST_SEC(50), .RST_MIN(59), .RST_HOUR(23), .RST_WDAY(6),
        .RST_DAY(31), .RST_MON(12), .RST_YEAR(99)
    ) u_rtc_nibble_port (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .tick_1s(tick_1s), .rd_data(rd_data), .flags(flags)
    );

    function automatic int exp_nib(input int d);
        case (d)
            0:  return m_sec % 10;
            1:  return m_sec / 10;
            2:  return m_min % 10;
            3:  return m_min / 10;
            4:  return m_hour % 10;
            5:  return 8 + m_hour / 10;
            6:  return m_wday;
            7:  return m_day % 10;
            8:  return m_day / 10;
            9:  return m_mon % 10;
            10: return m_mon / 10;
            11: return m_year % 10;
            12: return m_year / 10;
            default: return 0;
        endcase
    endfunction

    task automatic model_tick();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_day++;
                    if (m_day == 32) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cmd_write(input logic [7:0] b);
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_sel(input int d, input string req);
        reg_sel = 1'b1;
        #1;
        check(req, rd_data, exp_nib(d));
    endtask

    task automatic sweep(input logic [3:0] flag_nib, input string req);
        for (int d = 0; d < 16; d++) begin
            cmd_write({flag_nib, 4'(d)});
            read_sel(d, (d == 5) ? "R5" : (d > 12) ? "R6" : req);
        end
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tick_1s = 1'b1;
        repeat (n) begin
            @(negedge clk);
            model_tick();
        end
        tick_1s = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // R1: reset state
                #1;
                check("R1 flags", flags, 0);
                reg_sel = 1'b1;
                #1;
                check("R1 ptr0", rd_data, exp_nib(0));
                // R3: command read
                reg_sel = 1'b0;
                #1;
                check("R3", rd_data, 8'hFF);
                sweep(4'h0, "R1 R4");
                // R8 R9 R11: tick through every wrap
                for (int t = 0; t < 12; t++) begin
                    do_ticks(1);
                    sweep(4'h0, "R9 R11");
                end
                // R2: command fields
                cmd_write(8'hB3);
                #1;
                check("R2 flags", flags, 4'hB);
                read_sel(3, "R2 ptr");
                // R10: hold
                cmd_write(8'h40);
                check("R10 flags", flags, 4'h4);
                do_ticks(0);
                @(negedge clk); tick_1s = 1'b1;
                repeat (5) @(negedge clk);
                tick_1s = 1'b0;
                sweep(4'h4, "R10");
                // R7: data-port write has no effect
                cmd_write(8'h57);
                @(negedge clk);
                reg_sel = 1'b1; wr_en = 1'b1; wr_data = 8'h3C;
                @(negedge clk);
                wr_en = 1'b0;
                #1;
                check("R7 flags", flags, 4'h5);
                check("R7 ptr", rd_data, exp_nib(7));
                sweep(4'h0, "R7");
                // R8 R11: one full day
                do_ticks(86400);
                sweep(4'h0, "R8 R11");
                for (int t = 0; t < 3; t++) begin
                    do_ticks(3600 * 7);
                    sweep(4'h0, "R5 R9");
                end
            end
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule